// File: doc/BRIEF.md
# Six-Channel Paired Down-Counter Timer Unit

This peripheral holds six independent down-counting timers, organised as three identical groups of two (an A and a B timer per group), behind a flat 32-bit register bus. Software writes a byte offset, a write strobe and write data. Read data is returned combinationally for the offset currently on the bus. A unit-wide clock control word gates the whole block. Every timer has four registers:

- a control word that picks the count source and mode;
- a run word that starts or stops it and can request a load from the reload value;
- the reload value itself;
- the live count.

A running timer steps down once per clock while the unit is active. When it expires it takes its reload value again and latches a pending flag in a shared capture register. Software clears that flag by writing a one to it. Each timer drives its own interrupt line, which is the pending flag qualified by a shared enable mask. A read-only identification word lets software confirm that the unit is present.

Top module: `hex_timer_unit`

## Requirements
- R1: After reset, every register reads zero and every interrupt line is low. Offset 0x08 always reads the identification constant (default 0x59) in bits 15:8, with all other bits zero.
- R2: Offset 0x00 is the unit clock control word. Bit 0 disables the unit, bit 4 wakes it from suspend, and bit 8 selects run mode. All three bits read back. The unit is active only when bit 4 is 1 and bit 0 is 0.
- R3: While the unit is not active, every timer keeps its count. Every write to an offset other than 0x00 is ignored, including clears of the capture register.
- R4: Timer t (0..5) lives in group g = t/2. Its slot base is 0x10 + 0x20·g, plus 4 when t is odd. From the slot base, control is at +0x00, run at +0x08, reload at +0x10 and count at +0x18. Reload and count hold CNT_W bits; higher write bits are dropped.
- R5: The control word stores bits 10, 8, 7 and 2, and its other bits read as zero. A timer counts only when both bit 10 (internal clock source) and bit 2 (counter mode) are set.
- R6: In the run word, writing bit 0 = 1 starts the timer and bit 0 = 0 stops it without changing its count. Writing bit 2 = 1 loads the count from the reload register. The run word reads back the running state in bit 0.
- R7: Each clock, an active, running, enabled timer decrements by one. If its count is 1 or 0 on such a clock, it instead takes the reload value and sets its capture bit t.
- R8: Offset 0xF4 is the interrupt enable mask (bits 5:0) and offset 0xF8 is a 6-bit interrupt control word; both read back. irq_o[t] is high exactly when capture bit t and enable bit t are both set.
- R9: Offset 0xFC reads the pending capture bits. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An expiry in the same clock as a clear leaves the bit set.
- R10: A write to a count register sets the count directly and has priority over a load and over counting. Reading a count register returns the live value. Any other offset, including any offset that is not word aligned, reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current offset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 6 | Per-timer interrupt lines |

## Verification
The bench builds the unit with CNT_W = 8. This makes the truncation of wide writes to the reload and count registers directly visible, and it keeps reload values small enough that many expiries, reloads and captures fit into a short run. The identification constant keeps its default, so the 0x59 readback is exercised as it would be in use.

// File: rtl/hex_timer_unit.sv
module hex_timer_unit #(
  parameter int CNT_W = 16,
  parameter logic [7:0] ID_CODE = 8'h59
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [5:0]  irq_o
);
  localparam int NT = 6;
  localparam logic [7:0] A_CLC  = 8'h00;
  localparam logic [7:0] A_ID   = 8'h08;
  localparam logic [7:0] A_IEN  = 8'hF4;
  localparam logic [7:0] A_ICTL = 8'hF8;
  localparam logic [7:0] A_ICAP = 8'hFC;

  function automatic logic [7:0] slot(input int t, input int r);
    return 8'(16 + (t / 2) * 32 + (t % 2) * 4 + r * 8);
  endfunction

  logic clc_dis, clc_wake, clc_run, active, gw;
  logic [NT-1:0] ien, ictl, pend, running, tick, expire;
  logic [3:0] con [NT];
  logic [CNT_W-1:0] rld [NT];
  logic [CNT_W-1:0] cnt [NT];
  logic [NT*CNT_W-1:0] cnt_flat;

  assign active = clc_wake & ~clc_dis;
  assign gw     = bus_we & active;
  assign irq_o  = pend & ien;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      tick[i]   = active & running[i] & con[i][3] & con[i][0];
      expire[i] = tick[i] && (cnt[i] <= CNT_W'(1));
      cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clc_dis  <= 1'b0;
      clc_wake <= 1'b0;
      clc_run  <= 1'b0;
      ien      <= '0;
      ictl     <= '0;
      pend     <= '0;
      running  <= '0;
      for (int i = 0; i < NT; i++) begin
        con[i] <= '0;
        rld[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      if (bus_we && bus_addr == A_CLC)
        {clc_run, clc_wake, clc_dis} <= {bus_wdata[8], bus_wdata[4], bus_wdata[0]};
      if (gw && bus_addr == A_IEN)  ien  <= bus_wdata[NT-1:0];
      if (gw && bus_addr == A_ICTL) ictl <= bus_wdata[NT-1:0];
      pend <= (pend & ~((gw && bus_addr == A_ICAP) ? bus_wdata[NT-1:0] : '0)) | expire;
      for (int i = 0; i < NT; i++) begin
        if (gw && bus_addr == slot(i, 0))
          con[i] <= {bus_wdata[10], bus_wdata[8], bus_wdata[7], bus_wdata[2]};
        if (gw && bus_addr == slot(i, 1))
          running[i] <= bus_wdata[0];
        if (gw && bus_addr == slot(i, 2))
          rld[i] <= bus_wdata[CNT_W-1:0];
        if (gw && bus_addr == slot(i, 3))
          cnt[i] <= bus_wdata[CNT_W-1:0];
        else if (gw && bus_addr == slot(i, 1) && bus_wdata[2])
          cnt[i] <= rld[i];
        else if (expire[i])
          cnt[i] <= rld[i];
        else if (tick[i])
          cnt[i] <= cnt[i] - CNT_W'(1);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CLC:   bus_rdata = 32'({clc_run, 3'b0, clc_wake, 3'b0, clc_dis});
      A_ID:    bus_rdata = {16'b0, ID_CODE, 8'b0};
      A_IEN:   bus_rdata = 32'(ien);
      A_ICTL:  bus_rdata = 32'(ictl);
      A_ICAP:  bus_rdata = 32'(pend);
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < NT; i++) begin
      if (bus_addr == slot(i, 0))
        bus_rdata = 32'({con[i][3], 1'b0, con[i][2], con[i][1], 4'b0, con[i][0], 2'b0});
      if (bus_addr == slot(i, 1)) bus_rdata = 32'(running[i]);
      if (bus_addr == slot(i, 2)) bus_rdata = 32'(rld[i]);
      if (bus_addr == slot(i, 3)) bus_rdata = 32'(cnt[i]);
    end
  end

  // R3
  idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(cnt_flat));

  // R3
  idle_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(ien));

  for (genvar g = 0; g < NT; g++) begin : g_chk
    // R7
    pend_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[g] && !tick[g]) |=> !pend[g]);

    // R7
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[g] && cnt[g] > CNT_W'(1) && !bus_we) |=> cnt[g] == CNT_W'($past(cnt[g]) - CNT_W'(1)));

    // R9
    capture_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gw && bus_addr == A_ICAP && bus_wdata[g] && !expire[g]) |=> !pend[g]);

    // R6
    stop_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gw && bus_addr == slot(g, 1) && !bus_wdata[0]) |=> !running[g]);
  end
endmodule

// File: tb/sim_hex_timer_unit.sv
module sim_hex_timer_unit;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;

  always #2 clk = ~clk;

  hex_timer_unit #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  int nchk = 0;
  int nfail = 0;

  int m_dis, m_wake, m_run;
  bit [5:0] m_ien, m_ictl, m_pend, m_running;
  int m_con [6];
  int m_rld [6];
  int m_cnt [6];

  function automatic int taddr(int t, int r);
    return 16 + (t / 2) * 32 + (t % 2) * 4 + r * 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint exp_read(int a);
    if (a == 0)     return (m_run << 8) | (m_wake << 4) | m_dis;
    if (a == 8)     return 'h5900;
    if (a == 'hF4)  return m_ien;
    if (a == 'hF8)  return m_ictl;
    if (a == 'hFC)  return m_pend;
    for (int t = 0; t < 6; t++) begin
      if (a == taddr(t, 0)) return m_con[t];
      if (a == taddr(t, 1)) return m_running[t];
      if (a == taddr(t, 2)) return m_rld[t];
      if (a == taddr(t, 3)) return m_cnt[t];
    end
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R2";
    if (a == 8) return "R1";
    if (a == 'hF4 || a == 'hF8) return "R8";
    if (a == 'hFC) return "R9";
    for (int t = 0; t < 6; t++) begin
      if (a == taddr(t, 0)) return "R5";
      if (a == taddr(t, 1)) return "R6";
      if (a == taddr(t, 2)) return "R4";
    end
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dis = 0; m_wake = 0; m_run = 0;
      m_ien = 0; m_ictl = 0; m_pend = 0; m_running = 0;
      for (int t = 0; t < 6; t++) begin m_con[t] = 0; m_rld[t] = 0; m_cnt[t] = 0; end
    end else begin
      bit act;
      bit [5:0] tk, ex, clr;
      act = (m_wake == 1) && (m_dis == 0);
      for (int t = 0; t < 6; t++) begin
        tk[t] = act && m_running[t] && (m_con[t] & 'h400) != 0 && (m_con[t] & 'h4) != 0;
        ex[t] = tk[t] && m_cnt[t] <= 1;
      end
      clr = (we && act && addr == 8'hFC) ? wdata[5:0] : 6'b0;
      m_pend = (m_pend & ~clr) | ex;
      for (int t = 0; t < 6; t++) begin
        if (we && act && addr == taddr(t, 3)) m_cnt[t] = wdata & 'hFF;
        else if (we && act && addr == taddr(t, 1) && wdata[2]) m_cnt[t] = m_rld[t];
        else if (ex[t]) m_cnt[t] = m_rld[t];
        else if (tk[t]) m_cnt[t] = m_cnt[t] - 1;
        if (we && act && addr == taddr(t, 0)) m_con[t] = wdata & 'h584;
        if (we && act && addr == taddr(t, 1)) m_running[t] = wdata[0];
        if (we && act && addr == taddr(t, 2)) m_rld[t] = wdata & 'hFF;
      end
      if (we && act && addr == 8'hF4) m_ien = wdata[5:0];
      if (we && act && addr == 8'hF8) m_ictl = wdata[5:0];
      if (we && addr == 8'h00) begin
        m_dis = wdata[0]; m_wake = wdata[4]; m_run = wdata[8];
      end
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk(rdata == exp_read(addr), tag_of(addr), rdata, exp_read(addr));
      chk(irq == (m_pend & m_ien), "R8", irq, m_pend & m_ien);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 8'(a); wdata = 32'(d);
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    we = 1'b0; addr = 8'(a);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) rd(taddr(0, 3));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(0);   chk(rdata == 0, "R1", rdata, 0);
    rd(8);   chk(rdata == 32'h5900, "R1", rdata, 32'h5900);
    rd('hFC); chk(irq == 0, "R1", irq, 0);

    wr(taddr(0, 0), 'h584);
    wr('hF4, 'h3F);
    rd(taddr(0, 0)); chk(rdata == 0, "R3", rdata, 0);
    rd('hF4);        chk(rdata == 0, "R3", rdata, 0);

    wr(0, 'h110);
    rd(0); chk(rdata == 32'h110, "R2", rdata, 32'h110);

    wr(taddr(0, 0), 'hFFFF);
    rd(taddr(0, 0)); chk(rdata == 32'h584, "R5", rdata, 32'h584);
    wr(taddr(0, 2), 3);
    wr(taddr(0, 1), 5);
    wr('hF4, 1);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      rd(taddr(0, 3));
      if (irq[0]) seen = 1;
    end
    chk(seen == 1, "R7", seen, 1);
    wr('hFC, 1);
    rd('hFC);

    wr(taddr(5, 0), 'h400);
    wr(taddr(5, 2), 2);
    wr(taddr(5, 1), 5);
    idle(6);
    rd(taddr(5, 3)); chk(rdata == 2, "R5", rdata, 2);

    wr(taddr(3, 0), 'h584);
    wr(taddr(3, 2), 1);
    wr(taddr(3, 1), 1);
    wr('hF4, 'h3F);
    wr('hF8, 'h2A);
    idle(5);
    rd('hFC); chk(rdata[3] == 1'b1, "R9", rdata[3], 1);
    wr('hFC, 'h3F);
    rd('hFC);

    wr(taddr(0, 1), 0);
    rd(taddr(0, 3)); seen = int'(rdata);
    idle(4);
    rd(taddr(0, 3)); chk(int'(rdata) == seen, "R6", rdata, seen);
    rd(taddr(0, 1)); chk(rdata == 0, "R6", rdata, 0);

    wr(taddr(2, 3), 'h1FF);
    rd(taddr(2, 3)); chk(rdata == 32'hFF, "R10", rdata, 32'hFF);
    wr(taddr(1, 2), 'h155);
    rd(taddr(1, 2)); chk(rdata == 32'h55, "R4", rdata, 32'h55);

    wr(taddr(4, 0), 'h584);
    wr(taddr(4, 2), 'h40);
    wr(taddr(4, 1), 5);
    idle(3);
    wr(0, 'h100);
    rd(taddr(4, 3)); seen = int'(rdata);
    idle(5);
    rd(taddr(4, 3)); chk(int'(rdata) == seen, "R3", rdata, seen);
    wr(0, 'h111);
    wr('hF4, 0);
    wr('hFC, 'h3F);
    rd('hF4); chk(rdata == 32'h3F, "R3", rdata, 32'h3F);
    rd(0);    chk(rdata == 32'h111, "R2", rdata, 32'h111);

    rd('h09); chk(rdata == 0, "R10", rdata, 0);
    rd('hF0); chk(rdata == 0, "R10", rdata, 0);

    wr(0, 'h010);
    for (int t = 0; t < 6; t++) wr(taddr(t, 2), t + 16);
    for (int t = 0; t < 6; t++) begin
      rd(taddr(t, 2)); chk(rdata == 32'(t + 16), "R4", rdata, t + 16);
    end
    idle(40);
    finish_run();
  end
endmodule